// File: doc/BRIEF.md
# DMA Descriptor Configuration Error Checker

This block screens a DMA channel's transfer descriptor when the channel starts and watches the bus responses while the transfer runs. A descriptor is checked in the cycle its start strobe is high. The check covers four things: address and offset alignment on both sides, against the access size of that side; a 32-byte alignment rule for the next-descriptor address when descriptor chaining is on; and the consistency of the byte count and iteration counts. Bus errors and a cancelled-transfer indication may arrive in any cycle.

All findings collect in a sticky error-status word. The word holds one flag per error kind, the channel number of the first event, a cancel flag and a top valid bit. When halt-on-error is enabled, any error also raises a halt. While the halt is up, service requests are not granted and channel starts are not checked. A software clear input empties the status word and drops the halt.

Top module: `dma_desc_checker`

## Requirements
- R1: After reset the status word is all zero and halt is low.
- R2: Size codes 0 to 5 mean accesses of 1, 2, 4, 8, 16 and 32 bytes; codes 6 and 7 are treated as 32 bytes. On a checked start, status bit 7 is set when the source address is not a multiple of the source access size, and bit 6 is set when the source offset is not.
- R3: On a checked start, status bit 5 is set when the destination address is misaligned to the destination access size, and bit 4 is set when the destination offset is misaligned.
- R4: On a checked start with chaining enabled, status bit 2 is set when the low 5 bits of the next-descriptor address are not all zero. With chaining disabled, that address is not checked.
- R5: On a checked start, status bit 3 is set when the byte count is zero, the begin count is zero, or the current count differs from the begin count.
- R6: A source bus error sets status bit 1, and a destination bus error sets status bit 0. Either may arrive in any cycle and shows one cycle later.
- R7: A cancelled-transfer pulse sets status bit 13, which is the bit just above the channel field.
- R8: Status bit 14, the top bit, is 1 exactly when any of bits 0 to 7 or bit 13 is set.
- R9: Status bits 12:8 capture the channel input of the first event after reset or clear. Later events do not change them. A clear with no event returns them to zero.
- R10: Flags are sticky until clear. A clear in the same cycle as a new event leaves only that new event recorded, together with its channel.
- R11: An error (bits 0 to 7) raises halt one cycle later if halt-on-error is enabled in that cycle. A cancel alone does not raise halt. Clear lowers halt.
- R12: While halt is high, the service grant is low and start strobes are ignored, so no descriptor flags are set. Otherwise the grant follows the service request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_on_err_en | input | 1 | Enables halting on any error |
| clr | input | 1 | Software clear of status and halt |
| chk_stb | input | 1 | Channel start: check the descriptor this cycle |
| chan | input | CH_W | Channel number of the current activity |
| src_addr | input | ADDR_W | Source address |
| src_off | input | OFF_W | Signed source offset |
| src_size | input | 3 | Source access size code |
| dst_addr | input | ADDR_W | Destination address |
| dst_off | input | OFF_W | Signed destination offset |
| dst_size | input | 3 | Destination access size code |
| nbytes | input | NB_W | Bytes per inner iteration |
| biter | input | CNT_W | Begin iteration count |
| citer | input | CNT_W | Current iteration count |
| sg_en | input | 1 | Descriptor chaining enable |
| sg_addr | input | ADDR_W | Next-descriptor address |
| src_bus_err | input | 1 | Source bus error response |
| dst_bus_err | input | 1 | Destination bus error response |
| cancel | input | 1 | Transfer cancelled pulse |
| svc_req | input | 1 | Incoming service request |
| svc_grant | output | 1 | Service request passed on while not halted |
| halt | output | 1 | Halted after an error |
| err_status | output | CH_W+10 | Flags, first channel, cancel flag, valid bit |

## Verification
The clear and the recording of a new error can fall in the same cycle, and so can the halt and an incoming start strobe. The bench provokes the first by raising a bus error on a fresh channel while clear is high, over a word that already holds earlier flags. It then expects only the new flag and the new channel number. It provokes the second by strobing a bad descriptor while halted, and expects no new flags and no grant. Random trials mix clear, strobes, bus errors and cancels freely, and a per-cycle model judges each result.

// File: rtl/dma_desc_checker.sv
module dma_desc_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W = 16,
  parameter int NB_W = 32,
  parameter int CNT_W = 15,
  parameter int CH_W = 5,
  parameter int SG_LG = 5,
  localparam int ST_W = CH_W + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_on_err_en,
  input  logic              clr,
  input  logic              chk_stb,
  input  logic [CH_W-1:0]   chan,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [2:0]        src_size,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic [2:0]        dst_size,
  input  logic [NB_W-1:0]   nbytes,
  input  logic [CNT_W-1:0]  biter,
  input  logic [CNT_W-1:0]  citer,
  input  logic              sg_en,
  input  logic [ADDR_W-1:0] sg_addr,
  input  logic              src_bus_err,
  input  logic              dst_bus_err,
  input  logic              cancel,
  input  logic              svc_req,
  output logic              svc_grant,
  output logic              halt,
  output logic [ST_W-1:0]   err_status
);

  logic [4:0]      s_mask, d_mask;
  logic            live;
  logic [7:0]      ev;
  logic            any_ev, base_empty;
  logic [7:0]      flags_q;
  logic            cx_q;
  logic [CH_W-1:0] ch_q;
  logic            halt_q;

  assign s_mask = (src_size >= 3'd5) ? 5'h1f : 5'((6'd1 << src_size) - 6'd1);
  assign d_mask = (dst_size >= 3'd5) ? 5'h1f : 5'((6'd1 << dst_size) - 6'd1);
  assign live   = chk_stb & ~halt_q;

  assign ev[7] = live & (|(src_addr[4:0] & s_mask));
  assign ev[6] = live & (|(src_off[4:0] & s_mask));
  assign ev[5] = live & (|(dst_addr[4:0] & d_mask));
  assign ev[4] = live & (|(dst_off[4:0] & d_mask));
  assign ev[3] = live & ((nbytes == '0) | (biter == '0) | (citer != biter));
  assign ev[2] = live & sg_en & (|sg_addr[SG_LG-1:0]);
  assign ev[1] = src_bus_err;
  assign ev[0] = dst_bus_err;

  assign any_ev     = (|ev) | cancel;
  assign base_empty = clr | ~((|flags_q) | cx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cx_q    <= 1'b0;
      ch_q    <= '0;
      halt_q  <= 1'b0;
    end else begin
      flags_q <= (clr ? 8'h00 : flags_q) | ev;
      cx_q    <= (clr ? 1'b0 : cx_q) | cancel;
      if (any_ev && base_empty) ch_q <= chan;
      else if (clr)             ch_q <= '0;
      halt_q  <= (clr ? 1'b0 : halt_q) | (halt_on_err_en & (|ev));
    end
  end

  assign halt       = halt_q;
  assign svc_grant  = svc_req & ~halt_q;
  assign err_status = {(|flags_q) | cx_q, cx_q, ch_q, flags_q};

endmodule

module dma_desc_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int CH_W = 5,
  parameter int SG_LG = 5,
  localparam int ST_W = CH_W + 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_on_err_en,
  input logic              clr,
  input logic              chk_stb,
  input logic              sg_en,
  input logic [ADDR_W-1:0] sg_addr,
  input logic              src_bus_err,
  input logic              dst_bus_err,
  input logic              cancel,
  input logic              svc_grant,
  input logic              halt,
  input logic [ST_W-1:0]   err_status
);

  assert_halt_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !svc_grant);

  assert_halt_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_on_err_en && !halt) |=> !halt);

  assert_valid_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status[ST_W-1] && !clr) |=> err_status[ST_W-1]);

  assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status[ST_W-1] && !clr) |=> $stable(err_status[8 +: CH_W]));

  assert_src_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_bus_err |=> err_status[1]);

  assert_sg_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_stb && !halt && sg_en && (sg_addr[SG_LG-1:0] != '0)) |=> err_status[2]);

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !chk_stb && !src_bus_err && !dst_bus_err && !cancel) |=> (err_status == '0));

endmodule

bind dma_desc_checker dma_desc_checker_sva #(.ADDR_W(ADDR_W), .CH_W(CH_W), .SG_LG(SG_LG)) u_sva (.*);

// File: tb/dma_desc_checker_bench.sv
`timescale 1ns/1ps
module dma_desc_checker_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic halt_on_err_en, clr, chk_stb, sg_en, src_bus_err, dst_bus_err, cancel, svc_req;
  logic [4:0]  chan;
  logic [31:0] src_addr, dst_addr, nbytes, sg_addr;
  logic [15:0] src_off, dst_off;
  logic [2:0]  src_size, dst_size;
  logic [14:0] biter, citer;
  logic svc_grant, halt;
  logic [14:0] err_status;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_flags = '0;
  logic       m_cx = 1'b0, m_halt = 1'b0;
  logic [4:0] m_ch = '0;

  always #2 clk = ~clk;

  dma_desc_checker u_dma_desc_checker (.*);

  function automatic logic [4:0] amask(input logic [2:0] sz);
    return (sz >= 3'd5) ? 5'h1f : 5'((32'd1 << sz) - 32'd1);
  endfunction

  function automatic logic [7:0] desc_flags();
    logic [7:0] f = '0;
    f[7] = (src_addr[4:0] & amask(src_size)) != 0;
    f[6] = (src_off[4:0]  & amask(src_size)) != 0;
    f[5] = (dst_addr[4:0] & amask(dst_size)) != 0;
    f[4] = (dst_off[4:0]  & amask(dst_size)) != 0;
    f[3] = (nbytes == 0) || (biter == 0) || (citer != biter);
    f[2] = sg_en && (sg_addr[4:0] != 0);
    return f;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic benign();
    halt_on_err_en = 0; clr = 0; chk_stb = 0; sg_en = 0; src_bus_err = 0;
    dst_bus_err = 0; cancel = 0; svc_req = 0; chan = 0;
    src_addr = 32'h100; dst_addr = 32'h200; src_off = 16'd4; dst_off = 16'd4;
    src_size = 3'd2; dst_size = 3'd2; nbytes = 32'd16; biter = 15'd8; citer = 15'd8;
    sg_addr = 32'h400;
  endtask

  task automatic step(string tag);
    logic [7:0] ev;
    logic any, empty;
    ev = (chk_stb && !m_halt) ? desc_flags() : 8'h00;
    ev[1] = src_bus_err;
    ev[0] = dst_bus_err;
    any = (ev != 0) || cancel;
    empty = clr || (m_flags == 0 && !m_cx);
    @(posedge clk); @(negedge clk);
    if (any && empty) m_ch = chan; else if (clr) m_ch = '0;
    m_flags = (clr ? 8'h00 : m_flags) | ev;
    m_cx    = (clr ? 1'b0 : m_cx) | cancel;
    m_halt  = (clr ? 1'b0 : m_halt) | (halt_on_err_en && ev != 0);
    check({tag, " R8 status"}, 32'(err_status), 32'({(m_flags != 0) || m_cx, m_cx, m_ch, m_flags}));
    check({tag, " R11 halt"}, 32'(halt), 32'(m_halt));
    check({tag, " R12 grant"}, 32'(svc_grant), 32'(svc_req && !m_halt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    benign();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset status", 32'(err_status), 0);
    check("R1 reset halt", 32'(halt), 0);

    // R2: size code 7 treated as 32 bytes
    chk_stb = 1; chan = 5'd3; src_size = 3'd7; src_addr = 32'h110; src_off = 16'd32;
    step("R2 clip");
    check("R2 src addr bit7", 32'(err_status[7]), 1);
    benign(); clr = 1; step("R10 clear");

    // R3 dest offsets, negative offset aligned
    chk_stb = 1; chan = 5'd4; dst_size = 3'd1; dst_addr = 32'h201; dst_off = 16'hfffe;
    step("R3 dst");
    check("R3 dst addr only", 32'(err_status[5:4]), 32'b10);
    benign();

    // R9/R10: second event on another channel keeps first channel
    src_bus_err = 1; chan = 5'd9; step("R9 second");
    check("R9 channel kept", 32'(err_status[12:8]), 4);
    benign();

    // R10/R9: clear with a new event in the same cycle
    clr = 1; dst_bus_err = 1; chan = 5'd6; step("R10 clr+err");
    check("R10 only new flag", 32'(err_status), 32'({1'b1, 1'b0, 5'd6, 8'h01}));
    benign();

    // R4: chaining off, misaligned next address ignored; R5 zero count
    clr = 1; step("R4 pre");
    benign(); chk_stb = 1; sg_addr = 32'h404; nbytes = 0; step("R5 zero");
    check("R4 sg ignored", 32'(err_status[2]), 0);
    check("R5 count flag", 32'(err_status[3]), 1);
    benign(); clr = 1; step("R4 clr");
    benign(); chk_stb = 1; sg_en = 1; sg_addr = 32'h410; step("R4 sg");
    check("R4 sg flag", 32'(err_status[2]), 1);

    // R7/R11: cancel alone does not halt
    benign(); clr = 1; step("R7 clr");
    benign(); halt_on_err_en = 1; cancel = 1; chan = 5'd2; step("R7 cancel");
    check("R7 cancel bit", 32'(err_status[13]), 1);
    check("R11 no halt on cancel", 32'(halt), 0);

    // R11/R12: halt then ignore start and requests
    benign(); halt_on_err_en = 1; chk_stb = 1; citer = 15'd3; step("R11 halt");
    check("R11 halt up", 32'(halt), 1);
    benign(); chk_stb = 1; svc_req = 1; src_addr = 32'h103; step("R12 ignored");
    check("R12 no src flag", 32'(err_status[7]), 0);
    check("R12 grant low", 32'(svc_grant), 0);
    benign(); clr = 1; svc_req = 1; step("R11 clr");
    check("R12 grant back", 32'(svc_grant), 1);

    // random mix for R2..R12
    for (int i = 0; i < 400; i++) begin
      benign();
      halt_on_err_en = ($urandom % 4) == 0;
      clr = ($urandom % 5) == 0;
      chk_stb = ($urandom % 3) != 0;
      chan = 5'($urandom);
      src_size = 3'($urandom); dst_size = 3'($urandom);
      src_addr = ($urandom % 3 == 0) ? $urandom : ($urandom & 32'hffffffe0);
      dst_addr = ($urandom % 3 == 0) ? $urandom : ($urandom & 32'hffffffe0);
      src_off = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom & 32'hffe0);
      dst_off = ($urandom % 3 == 0) ? 16'($urandom) : 16'($urandom & 32'hffe0);
      nbytes = ($urandom % 8 == 0) ? 0 : 32'($urandom % 64 + 1);
      biter = ($urandom % 8 == 0) ? 0 : 15'($urandom % 16 + 1);
      citer = ($urandom % 6 == 0) ? 15'($urandom % 16) : biter;
      sg_en = $urandom % 2;
      sg_addr = ($urandom % 2) ? $urandom : ($urandom & 32'hffffffe0);
      src_bus_err = ($urandom % 10) == 0;
      dst_bus_err = ($urandom % 10) == 0;
      cancel = ($urandom % 12) == 0;
      svc_req = $urandom % 2;
      step("R2/R3/R4/R5/R6/R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule